// File: doc/BRIEF.md
# Two-Wire Bus Target Clock-Stretch Controller

This block sits on the target side of a two-wire serial bus and decides when the target holds the clock line low. It takes the raw clock and data lines, passes them through a synchronizer, and finds START and STOP conditions and falling clock edges. It then drives one open-drain pull-down enable for the clock line. A 1 on this enable pulls the line low. A 0 releases it.

Three independent sources can ask for a stretch:

- **Wake-up hold.** After a START that arrives while the local wake-up signal is not ready, the clock is held until that signal asserts.
- **Per-bit hold.** After a START, every clock low phase is lengthened by a programmable number of system clocks. This lowers the effective bus rate.
- **Byte hold.** On demand from the byte engine, the clock is held either before or after the acknowledge bit, until the engine reports ready.

The controller only starts pulling after it has seen the clock line low. It therefore lengthens a low phase and never cuts a high phase short. The block has no data-line driver and takes no part in arbitration.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While reset is active and right after it, `scl_pull`, `start_det` and `stop_det` are 0.
- R2: A data-line fall while the synchronized clock is high gives exactly one single-cycle `start_det` pulse. A data-line rise while the clock is high gives exactly one single-cycle `stop_det` pulse.
- R3: `scl_pull` goes from 0 to 1 only in a cycle that follows a cycle in which the synchronized clock was low. A pending hold never pulls the line while the clock stays high.
- R4: A START seen while `wake_ready` is 0 makes the block hold the clock through the next low phase until `wake_ready` is 1. `scl_pull` is 0 in the cycle after `wake_ready` is sampled high. A START with `wake_ready` at 1 adds no hold.
- R5: After a START, each clock low phase is driven low for exactly `bit_stretch_len` system clocks. A value of 0 adds no stretch.
- R6: The per-bit stretch applies only between a START and the next STOP. With the bus idle, a clock low phase gets no stretch.
- R7: A one-cycle `byte_hold_req` pulse makes the block hold the next or current clock low phase. This is true whether the pulse comes while the clock is high (before the low phase) or during the low phase. `scl_pull` returns to 0 one system clock after `byte_ready` is sampled high.
- R8: A STOP clears a pending wake-up hold and a pending byte hold, so the low phase that follows gets no stretch.
- R9: When `byte_hold_req` and `byte_ready` are high in the same cycle, no byte hold is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| wake_ready | input | 1 | Local logic is awake and can accept a transfer |
| bit_stretch_len | input | CNT_W | System clocks added to every clock low phase; 0 turns it off |
| byte_hold_req | input | 1 | Single-cycle request for a byte-level hold |
| byte_ready | input | 1 | Byte engine is done; the byte hold ends |
| scl_pull | output | 1 | Open-drain enable: 1 pulls the clock line low |
| start_det | output | 1 | One-cycle pulse on a START |
| stop_det | output | 1 | One-cycle pulse on a STOP |

## Verification
The per-bit stretch is tried with a range of programmed lengths: zero, one, small values, and one longer than the master's own low phase. Each length is applied over two low phases in one transfer. A wrong count shows as an off-by-one. A stretch that only applies once shows up on the second phase. A length of zero separates "disabled" from "one cycle".

Byte holds are requested once while the clock is high and once during a low phase. This tells apart correct low-phase gating from a pull that starts on a high clock. Wake-up holds, STOPs with holds pending, and a request colliding with ready are each run on their own. This shows which source is still holding the line.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

   // Active stretch sources, one bit per requester.
   typedef struct packed {
      logic wake;
      logic bitp;
      logic byteh;
   } src_t;

   // Bus events decoded from the synchronized lines.
   typedef struct packed {
      logic start;
      logic stop;
      logic scl_fall;
   } bus_evt_t;

endpackage

// File: rtl/line_sync.sv
module line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] raw,
   output logic [LINES-1:0] synced,
   output logic [LINES-1:0] synced_q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("line_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '1;
         end else begin
            chain <= {chain[STAGES-2:0], raw[i]};
         end
      end
      assign synced[i] = chain[STAGES-1];
   end

   // One more stage so that edges can be seen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= '1;
      end else begin
         synced_q <= synced;
      end
   end

endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
   import stretch_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_s,
   input  logic     scl_q,
   input  logic     sda_s,
   input  logic     sda_q,
   output bus_evt_t evt
);

   always_comb begin
      evt.start    = scl_s & scl_q & sda_q & ~sda_s;
      evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
      evt.scl_fall = scl_q & ~scl_s;
   end

   // R2
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> !evt.start);
   // R2
   stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> !evt.stop);

endmodule

// File: rtl/stretch_sources.sv
module stretch_sources
   import stretch_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_evt_t         evt,
   input  logic             scl_pull,
   input  logic             wake_ready,
   input  logic [CNT_W-1:0] bit_len,
   input  logic             byte_req,
   input  logic             byte_ready,
   output src_t             src
);

   if (CNT_W < 1) begin : g_bad_width
      $error("stretch_sources: CNT_W must be at least 1");
   end

   logic             busy;
   logic             wake_pend;
   logic             byte_pend;
   logic [CNT_W-1:0] bit_cnt;

   // Transfer in progress: from a START up to the next STOP.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
      end else if (evt.stop) begin
         busy <= 1'b0;
      end else if (evt.start) begin
         busy <= 1'b1;
      end
   end

   // Wake-up hold after a START that finds local logic asleep.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_pend <= 1'b0;
      end else if (evt.stop || wake_ready) begin
         wake_pend <= 1'b0;
      end else if (evt.start) begin
         wake_pend <= 1'b1;
      end
   end

   // Byte-level hold; ready and STOP take priority over a request.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_pend <= 1'b0;
      end else if (evt.stop || byte_ready) begin
         byte_pend <= 1'b0;
      end else if (byte_req) begin
         byte_pend <= 1'b1;
      end
   end

   if (PERIODIC_EN) begin : g_periodic
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_cnt <= '0;
         end else if (evt.stop) begin
            bit_cnt <= '0;
         end else if (evt.scl_fall && busy) begin
            bit_cnt <= bit_len;
         end else if (scl_pull && (bit_cnt != '0)) begin
            bit_cnt <= bit_cnt - 1'b1;
         end
      end
   end else begin : g_no_periodic
      assign bit_cnt = '0;
   end

   always_comb begin
      src.wake  = wake_pend;
      src.bitp  = (bit_cnt != '0);
      src.byteh = byte_pend;
   end

   // R4
   wake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_ready |=> !wake_pend);
   // R7
   byte_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ready |=> !byte_pend);
   // R8
   stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (!wake_pend && !byte_pend && !busy));
   // R6
   idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bit_cnt == '0));

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
   import stretch_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   input  logic             wake_ready,
   input  logic [CNT_W-1:0] bit_stretch_len,
   input  logic             byte_hold_req,
   input  logic             byte_ready,
   output logic             scl_pull,
   output logic             start_det,
   output logic             stop_det
);

   localparam int LINE_SCL = 0;
   localparam int LINE_SDA = 1;
   localparam int N_LINES  = 2;

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] lines_s;
   logic [N_LINES-1:0] lines_q;
   bus_evt_t           evt;
   src_t               src;
   logic               any_src;
   logic               armed;

   assign raw_lines[LINE_SCL] = scl_in;
   assign raw_lines[LINE_SDA] = sda_in;

   line_sync #(.STAGES(SYNC_STAGES), .LINES(N_LINES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw_lines),
      .synced   (lines_s),
      .synced_q (lines_q)
   );

   bus_cond_detect u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (lines_s[LINE_SCL]),
      .scl_q (lines_q[LINE_SCL]),
      .sda_s (lines_s[LINE_SDA]),
      .sda_q (lines_q[LINE_SDA]),
      .evt   (evt)
   );

   stretch_sources #(.CNT_W(CNT_W), .PERIODIC_EN(PERIODIC_EN)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .scl_pull   (scl_pull),
      .wake_ready (wake_ready),
      .bit_len    (bit_stretch_len),
      .byte_req   (byte_hold_req),
      .byte_ready (byte_ready),
      .src        (src)
   );

   assign any_src = |src;

   // Arm only from a sampled low clock; stay armed while a source holds.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else begin
         armed <= any_src & (~lines_s[LINE_SCL] | armed);
      end
   end

   assign scl_pull  = armed & any_src;
   assign start_det = evt.start;
   assign stop_det  = evt.stop;

   // R3
   pull_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull) |-> $past(!lines_s[LINE_SCL]));
   // R2
   cond_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_det, stop_det}));
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!scl_pull && !start_det && !stop_det));

endmodule

// File: tb/sim_i2c_tgt_stretch.sv
module sim_i2c_tgt_stretch;

   localparam int CNT_W = 8;
   localparam int N_VEC = 8;
   // programmed per-bit stretch; the expected pulled cycles per low phase equal it (R5)
   localparam int LEN_TAB [N_VEC] = '{0, 1, 2, 3, 5, 8, 13, 30};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             m_scl = 1'b1;
   logic             m_sda = 1'b1;
   logic             wake_ready = 1'b1;
   logic [CNT_W-1:0] len = '0;
   logic             byte_req = 1'b0;
   logic             byte_ready = 1'b0;
   logic             scl_pull;
   logic             start_det;
   logic             stop_det;
   logic             scl_line;

   int n_chk = 0;
   int n_fail = 0;
   int n_start = 0;
   int n_stop = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign scl_line = m_scl & ~scl_pull;

   i2c_tgt_stretch #(.CNT_W(CNT_W)) u0 (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_in          (scl_line),
      .sda_in          (m_sda),
      .wake_ready      (wake_ready),
      .bit_stretch_len (len),
      .byte_hold_req   (byte_req),
      .byte_ready      (byte_ready),
      .scl_pull        (scl_pull),
      .start_det       (start_det),
      .stop_det        (stop_det)
   );

   always @(negedge clk) begin
      if (start_det) n_start++;
      if (stop_det)  n_stop++;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // SDA falls while SCL high; SCL left high.
   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; idle(5);
      m_sda = 1'b0; idle(5);
   endtask

   // SDA rises while SCL high.
   task automatic bus_stop_high();
      m_sda = 1'b1; idle(6);
   endtask

   // Master low phase of mlow cycles; counts pulled cycles until the line is high again.
   task automatic low_phase(input int mlow, output int pulls);
      pulls = 0;
      m_scl = 1'b0;
      repeat (mlow) begin
         @(negedge clk);
         if (scl_pull) pulls++;
      end
      m_scl = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (scl_pull) pulls++;
         else if (scl_line) break;
      end
      idle(5);
   endtask

   // Full transfer end: low phase with SDA low, SCL high, then SDA rises.
   task automatic bus_stop_full();
      int p;
      m_scl = 1'b0; m_sda = 1'b0; idle(4);
      m_scl = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (scl_line) break;
      end
      idle(5);
      bus_stop_high();
      p = 0;
   endtask

   task automatic pulse_req();
      byte_req = 1'b1; @(negedge clk); byte_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int p;
      int s0;
      int t0;
      // R1 reset state
      idle(3);
      chk("R1 pull in reset", int'(scl_pull), 0);
      chk("R1 start in reset", int'(start_det), 0);
      rst_n = 1'b1;
      idle(4);
      chk("R1 pull after reset", int'(scl_pull), 0);
      chk("R1 stop after reset", int'(stop_det), 0);

      // R5 / R2: vector table walk
      s0 = n_start; t0 = n_stop;
      for (int v = 0; v < N_VEC; v++) begin
         len = CNT_W'(LEN_TAB[v]);
         bus_start();
         low_phase(10, p);
         chk($sformatf("R5 len %0d phase A", LEN_TAB[v]), p, LEN_TAB[v]);
         low_phase(10, p);
         chk($sformatf("R5 len %0d phase B", LEN_TAB[v]), p, LEN_TAB[v]);
         bus_stop_full();
      end
      chk("R2 start pulses", n_start - s0, N_VEC);
      chk("R2 stop pulses", n_stop - t0, N_VEC);

      // R6: no stretch while idle
      len = 8'd5;
      low_phase(10, p);
      chk("R6 idle low phase", p, 0);
      len = '0;

      // R4: wake-up hold
      wake_ready = 1'b0;
      bus_start();
      m_scl = 1'b0; idle(20);
      chk("R4 held while asleep", int'(scl_pull), 1);
      m_scl = 1'b1; idle(3);
      chk("R4 line still low", int'(scl_line), 0);
      wake_ready = 1'b1;
      @(negedge clk);
      chk("R4 release one clock later", int'(scl_pull), 0);
      idle(4);
      bus_stop_full();
      bus_start();
      low_phase(10, p);
      chk("R4 ready start no hold", p, 0);
      bus_stop_full();

      // R3 / R7: byte hold requested while SCL high
      pulse_req();
      idle(8);
      chk("R3 no pull while high", int'(scl_pull), 0);
      m_scl = 1'b0; idle(10);
      chk("R7 hold before ack", int'(scl_pull), 1);
      m_scl = 1'b1; idle(3);
      byte_ready = 1'b1; @(negedge clk); byte_ready = 1'b0;
      chk("R7 release one clock", int'(scl_pull), 0);
      idle(3);
      chk("R7 line high", int'(scl_line), 1);

      // R7: byte hold requested during a low phase
      m_scl = 1'b0; idle(6);
      pulse_req();
      idle(5);
      chk("R7 hold after ack", int'(scl_pull), 1);
      m_scl = 1'b1; idle(4);
      byte_ready = 1'b1; @(negedge clk); byte_ready = 1'b0;
      chk("R7 release after ack", int'(scl_pull), 0);
      idle(5);

      // R8: STOP clears pending wake and byte holds
      wake_ready = 1'b0;
      bus_start();
      pulse_req();
      idle(3);
      bus_stop_high();
      wake_ready = 1'b1;
      low_phase(10, p);
      chk("R8 stop cleared holds", p, 0);
      wake_ready = 1'b0;
      bus_start();
      bus_stop_high();
      low_phase(10, p);
      chk("R8 wake cleared with ready low", p, 0);
      wake_ready = 1'b1;

      // R9: request and ready together
      byte_req = 1'b1; byte_ready = 1'b1;
      @(negedge clk);
      byte_req = 1'b0; byte_ready = 1'b0;
      low_phase(10, p);
      chk("R9 ready wins", p, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule